// File: doc/BRIEF.md
# Mode-Programmable Handshake Parallel Port

This block is one 8-bit peripheral port that a processor configures with control bytes and then moves data through with a strobe/ready handshake. The peripheral side has a strobe input (active low) and a ready output. Their meaning depends on the programmed mode. Four modes exist: byte output, byte input, bidirectional and per-bit control. In bidirectional mode the port also borrows a second strobe/ready pair, which normally belongs to a neighbouring port. That pair carries the input half of the handshake.

The processor side is deliberately thin. Bus decoding is done elsewhere and reaches this block as single-cycle strobes: load a control byte, load the output register, or read the port. Each strobe is qualified by a data byte or returns one. A completed handshake, or a matching bit pattern in control mode, raises a sticky interrupt request. The request stays up until an external acknowledge pulse clears it, which is where a priority chain would attach. Per-bit output enables tell the pad ring when to drive the peripheral bus.

Top module: `hsport`

## Requirements
- R1: For one cycle or more of `rst_n` low, the port ends up with these values: `pin_oe` all zero, `rdy_a`, `rdy_b` and `irq` low, output mode selected, interrupts disabled and the watch mask empty (no bit monitored).
- R2: A control byte whose bits 3:0 are 1111 selects the mode from bits 7:6 (00 output, 01 input, 10 bidirectional, 11 control). Bits 3:0 = 0111 form an interrupt word: bit 7 enable, bit 6 AND (1) or OR (0), bit 5 active-high (1) or active-low (0), and bit 4 meaning a watch-mask byte follows. Bits 3:0 = 0011 set only the enable from bit 7. Any other control byte is ignored.
- R3: In output mode a `wr_data` pulse loads the output register. From the next cycle `rdy_a` is high, `pin_out` carries the byte and all `pin_oe` bits are high.
- R4: In output mode, a rising edge of `stb_a_n` while data is pending drops `rdy_a` on the next cycle. If interrupts are enabled, it also raises `irq`.
- R5: In input mode `rdy_a` is high while the input register is empty. `pin_in` is captured on every clock while `stb_a_n` is low. The rising edge of `stb_a_n` marks the register full, drops `rdy_a` and, if enabled, raises `irq`.
- R6: In input mode `rd_data` returns the captured byte on `cpu_dout`, and `rdy_a` rises on the next cycle. A strobe that arrives while the register is full neither overwrites the data nor raises `irq`.
- R7: In bidirectional mode `pin_oe` is all ones only while `stb_a_n` is low. `rdy_a` is high while output data is pending, and the rising edge of `stb_a_n` empties the output register.
- R8: In bidirectional mode `stb_b_n`/`rdy_b` run the input handshake into the input register, following the input-mode rules. `rdy_b` is low in every other mode.
- R9: In control mode the strobes are ignored and `rdy_a` is low. The control byte written right after the mode byte sets the direction of each bit (1 = input, with its `pin_oe` bit low). A read returns `pin_in` for input bits and the output register for output bits.
- R10: In control mode, with interrupts enabled, `irq` rises in the cycle after the monitored bits first meet the programmed condition. A bit is monitored when its watch bit is set and it is an input. OR fires when any monitored bit is at the active level, AND fires when all of them are. No bit monitored means no interrupt.
- R11: `irq` stays high until an `irq_ack` pulse clears it. No event sets `irq` while interrupts are disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_ctl | input | 1 | Load `cpu_din` as a control byte |
| wr_data | input | 1 | Load `cpu_din` into the output register |
| rd_data | input | 1 | Read strobe; empties the input register in input and bidirectional modes |
| irq_ack | input | 1 | Clears the pending interrupt request |
| cpu_din | input | 8 | Byte from the processor side |
| cpu_dout | output | 8 | Byte to the processor side |
| stb_a_n | input | 1 | Primary strobe from the peripheral, active low |
| rdy_a | output | 1 | Primary ready to the peripheral |
| stb_b_n | input | 1 | Borrowed strobe used for input in bidirectional mode |
| rdy_b | output | 1 | Borrowed ready used for input in bidirectional mode |
| pin_in | input | 8 | Peripheral bus value seen at the pads |
| pin_out | output | 8 | Peripheral bus value to drive |
| pin_oe | output | 8 | Per-bit drive enable for the peripheral bus |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that both strobes and `pin_in` are already synchronous to `clk`. They also assume that `wr_ctl`, `wr_data`, `rd_data` and `irq_ack` are single-cycle pulses that never coincide. In bidirectional mode they assume that `stb_a_n` and `stb_b_n` are never low together, since that would put both sides on the bus at once. The bench changes every input on the falling clock edge and issues one processor strobe at a time. It opens the bidirectional input strobe only after the output strobe has closed, so all stimulus stays inside these assumptions.

// File: rtl/hsport_pkg.sv
// Shared encodings for the handshake parallel port.
// Assumes: control-byte layout as described in the block requirements.
package hsport_pkg;

    typedef enum logic [1:0] {
        MODE_OUT = 2'b00,
        MODE_IN  = 2'b01,
        MODE_BID = 2'b10,
        MODE_CTL = 2'b11
    } mode_e;

    localparam logic [3:0] NIB_MODE = 4'hF;  // mode select byte
    localparam logic [3:0] NIB_IRQW = 4'h7;  // full interrupt word
    localparam logic [3:0] NIB_IEN  = 4'h3;  // interrupt enable only

endpackage

// File: rtl/hsport_strb.sv
// Strobe edge detector.
// Assumes: stb_n is already synchronous to clk; idle level is high.
module hsport_strb (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_n,
    output logic act,
    output logic rise
);

    logic stb_q;

    // Remember the previous strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b1;
        else        stb_q <= stb_n;
    end

    assign act  = ~stb_n;
    assign rise = stb_n & ~stb_q;

endmodule

// File: rtl/hsport_ctl.sv
// Control-byte decoder: holds mode, direction, watch mask and interrupt setup.
// Assumes: wr_ctl is a one-cycle pulse; a pending direction or mask byte
// takes the next control write regardless of its contents.
module hsport_ctl
    import hsport_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctl,
    input  logic [DW-1:0] din,
    output mode_e         mode,
    output logic [DW-1:0] dir,
    output logic [DW-1:0] watch,
    output logic          ie,
    output logic          and_sel,
    output logic          hi_sel,
    output logic          mode_wr
);

    logic want_dir;
    logic want_mask;
    logic [3:0] nib;
    logic [1:0] msel;

    assign nib  = din[3:0];
    assign msel = din[DW-1 -: 2];

    // Mode-byte write strobe, used to arm the output drivers.
    assign mode_wr = wr_ctl && !want_dir && !want_mask && (nib == NIB_MODE);

    // Decode control bytes into configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= MODE_OUT;
            dir       <= '0;
            watch     <= '0;
            ie        <= 1'b0;
            and_sel   <= 1'b0;
            hi_sel    <= 1'b0;
            want_dir  <= 1'b0;
            want_mask <= 1'b0;
        end else if (wr_ctl) begin
            if (want_dir) begin
                dir      <= din;
                want_dir <= 1'b0;
            end else if (want_mask) begin
                watch     <= din;
                want_mask <= 1'b0;
            end else if (nib == NIB_MODE) begin
                mode     <= mode_e'(msel);
                want_dir <= (mode_e'(msel) == MODE_CTL);
            end else if (nib == NIB_IRQW) begin
                ie        <= din[DW-1];
                and_sel   <= din[DW-2];
                hi_sel    <= din[DW-3];
                want_mask <= din[DW-4];
            end else if (nib == NIB_IEN) begin
                ie <= din[DW-1];
            end
        end
    end

endmodule

// File: rtl/hsport_cond.sv
// Bit-pattern condition monitor for control mode.
// Assumes: pins are synchronous; hit is a one-cycle pulse on a new match.
module hsport_cond #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] pins,
    input  logic [DW-1:0] dir,
    input  logic [DW-1:0] watch,
    input  logic          and_sel,
    input  logic          hi_sel,
    output logic          hit
);

    logic [DW-1:0] mon;
    logic [DW-1:0] lvl;
    logic [DW-1:0] sel;
    logic          match;
    logic          match_q;

    assign mon = watch & dir;
    assign lvl = hi_sel ? pins : ~pins;
    assign sel = lvl & mon;

    // Evaluate the programmed AND/OR condition over monitored bits.
    always_comb begin
        if (mon == '0)   match = 1'b0;
        else if (and_sel) match = (sel == mon);
        else             match = (sel != '0);
    end

    // Track the previous match to fire only on a new match.
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= match;
    end

    assign hit = en && match && !match_q;

endmodule

// File: rtl/hsport.sv
// Mode-programmable handshake parallel port (top).
// Assumes: strobes and pin_in synchronous to clk; processor strobes are
// single-cycle and mutually exclusive; in bidirectional mode the two
// peripheral strobes are never low together.
module hsport
    import hsport_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctl,
    input  logic          wr_data,
    input  logic          rd_data,
    input  logic          irq_ack,
    input  logic [DW-1:0] cpu_din,
    output logic [DW-1:0] cpu_dout,
    input  logic          stb_a_n,
    output logic          rdy_a,
    input  logic          stb_b_n,
    output logic          rdy_b,
    input  logic [DW-1:0] pin_in,
    output logic [DW-1:0] pin_out,
    output logic [DW-1:0] pin_oe,
    output logic          irq
);

    localparam int NSTB = 2;

    mode_e         mode_q;
    logic [DW-1:0] dir_q;
    logic [DW-1:0] watch_q;
    logic          ie_q;
    logic          and_sel;
    logic          hi_sel;
    logic          mode_wr;

    logic [NSTB-1:0] stb_n_v;
    logic [NSTB-1:0] stb_act;
    logic [NSTB-1:0] stb_rise;

    logic [DW-1:0] out_reg;
    logic [DW-1:0] in_reg;
    logic          out_full;
    logic          in_full;
    logic          drv;
    logic          irq_q;

    logic out_rise;
    logic in_act;
    logic in_rise;
    logic ev_out;
    logic ev_in;
    logic ev_ctl;

    hsport_ctl #(.DW(DW)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctl  (wr_ctl),
        .din     (cpu_din),
        .mode    (mode_q),
        .dir     (dir_q),
        .watch   (watch_q),
        .ie      (ie_q),
        .and_sel (and_sel),
        .hi_sel  (hi_sel),
        .mode_wr (mode_wr)
    );

    assign stb_n_v = {stb_b_n, stb_a_n};

    generate
        for (genvar s = 0; s < NSTB; s++) begin : g_strb
            hsport_strb u_strb (
                .clk   (clk),
                .rst_n (rst_n),
                .stb_n (stb_n_v[s]),
                .act   (stb_act[s]),
                .rise  (stb_rise[s])
            );
        end
    endgenerate

    hsport_cond #(.DW(DW)) u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (mode_q == MODE_CTL),
        .pins    (pin_in),
        .dir     (dir_q),
        .watch   (watch_q),
        .and_sel (and_sel),
        .hi_sel  (hi_sel),
        .hit     (ev_ctl)
    );

    // Route the strobes to the output and input halves by mode.
    always_comb begin
        out_rise = 1'b0;
        in_act   = 1'b0;
        in_rise  = 1'b0;
        unique case (mode_q)
            MODE_OUT: out_rise = stb_rise[0];
            MODE_IN: begin
                in_act  = stb_act[0];
                in_rise = stb_rise[0];
            end
            MODE_BID: begin
                out_rise = stb_rise[0];
                in_act   = stb_act[1];
                in_rise  = stb_rise[1];
            end
            default: ;
        endcase
    end

    assign ev_out = out_rise && out_full;
    assign ev_in  = in_rise && !in_full;

    // Output register and its pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_reg  <= '0;
            out_full <= 1'b0;
        end else if (wr_data) begin
            out_reg  <= cpu_din;
            out_full <= 1'b1;
        end else if (out_rise) begin
            out_full <= 1'b0;
        end
    end

    // Input register: capture while strobed and empty, full on strobe end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_reg  <= '0;
            in_full <= 1'b0;
        end else begin
            if (in_act && !in_full) in_reg <= pin_in;
            if (ev_in)
                in_full <= 1'b1;
            else if (rd_data && (mode_q == MODE_IN || mode_q == MODE_BID))
                in_full <= 1'b0;
        end
    end

    // Bus drivers stay off until the port is first programmed or loaded.
    always_ff @(posedge clk) begin
        if (!rst_n)                  drv <= 1'b0;
        else if (wr_data || mode_wr) drv <= 1'b1;
    end

    // Sticky interrupt request, set by enabled events, cleared by ack.
    always_ff @(posedge clk) begin
        if (!rst_n)                             irq_q <= 1'b0;
        else if (ie_q && (ev_out || ev_in || ev_ctl)) irq_q <= 1'b1;
        else if (irq_ack)                       irq_q <= 1'b0;
    end

    // Ready lines by mode.
    always_comb begin
        unique case (mode_q)
            MODE_OUT: rdy_a = out_full;
            MODE_IN:  rdy_a = !in_full;
            MODE_BID: rdy_a = out_full;
            default:  rdy_a = 1'b0;
        endcase
    end
    assign rdy_b = (mode_q == MODE_BID) && !in_full;

    // Per-bit drive enable and read-back selection.
    generate
        for (genvar i = 0; i < DW; i++) begin : g_bit
            always_comb begin
                unique case (mode_q)
                    MODE_OUT: pin_oe[i] = drv;
                    MODE_IN:  pin_oe[i] = 1'b0;
                    MODE_BID: pin_oe[i] = stb_act[0];
                    default:  pin_oe[i] = !dir_q[i];
                endcase
            end
            always_comb begin
                unique case (mode_q)
                    MODE_OUT: cpu_dout[i] = out_reg[i];
                    MODE_CTL: cpu_dout[i] = dir_q[i] ? pin_in[i] : out_reg[i];
                    default:  cpu_dout[i] = in_reg[i];
                endcase
            end
        end
    endgenerate

    assign pin_out = out_reg;
    assign irq     = irq_q;

endmodule

// File: rtl/hsport_chk.sv
// Property checker for the handshake parallel port, attached by bind.
// Assumes: the input constraints listed in the brief.
module hsport_chk
    import hsport_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_ctl,
    input logic          wr_data,
    input logic          rd_data,
    input logic          irq_ack,
    input logic          stb_a_n,
    input logic          rdy_a,
    input logic          rdy_b,
    input logic [DW-1:0] pin_oe,
    input logic          irq,
    input mode_e         mode_q,
    input logic          ie_q
);

    logic rst_seen_q;

    // After a reset cycle the port must be quiet.
    always_ff @(posedge clk) begin
        if (rst_seen_q)
            AST_RESET_QUIET: assert (pin_oe == '0 && !rdy_a && !rdy_b && !irq); // R1
        rst_seen_q <= !rst_n;
    end

    AST_OUT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_OUT) && rdy_a && $rose(stb_a_n) && !wr_data && !wr_ctl |=> !rdy_a); // R4

    AST_IN_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_IN) && !rdy_a && !rd_data && !wr_ctl |=> !rdy_a); // R6

    AST_BID_BUS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_BID) && stb_a_n |-> (pin_oe == '0)); // R7

    AST_RDY_B_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_BID) |-> !rdy_b); // R8

    AST_CTL_NO_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_CTL) |-> !rdy_a); // R9

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_ack |=> irq); // R11

    AST_IRQ_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_q && !irq |=> !irq); // R11

endmodule

bind hsport hsport_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctl  (wr_ctl),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .irq_ack (irq_ack),
    .stb_a_n (stb_a_n),
    .rdy_a   (rdy_a),
    .rdy_b   (rdy_b),
    .pin_oe  (pin_oe),
    .irq     (irq),
    .mode_q  (mode_q),
    .ie_q    (ie_q)
);

// File: tb/hsport_tb.sv
// Directed bench for the handshake parallel port.
module hsport_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_ctl = 1'b0;
    logic          wr_data = 1'b0;
    logic          rd_data = 1'b0;
    logic          irq_ack = 1'b0;
    logic [DW-1:0] cpu_din = '0;
    logic [DW-1:0] cpu_dout;
    logic          stb_a_n = 1'b1;
    logic          rdy_a;
    logic          stb_b_n = 1'b1;
    logic          rdy_b;
    logic [DW-1:0] pin_in = '0;
    logic [DW-1:0] pin_out;
    logic [DW-1:0] pin_oe;
    logic          irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsport #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_data(wr_data),
        .rd_data(rd_data), .irq_ack(irq_ack), .cpu_din(cpu_din),
        .cpu_dout(cpu_dout), .stb_a_n(stb_a_n), .rdy_a(rdy_a),
        .stb_b_n(stb_b_n), .rdy_b(rdy_b), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic ctl(input logic [7:0] b);
        wr_ctl = 1'b1; cpu_din = b; tick(); wr_ctl = 1'b0;
    endtask

    task automatic wr(input logic [7:0] b);
        wr_data = 1'b1; cpu_din = b; tick(); wr_data = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; tick();
        chk("R1 pin_oe after reset", pin_oe, 8'h00);
        chk("R1 rdy_a after reset", rdy_a, 0);
        chk("R1 rdy_b after reset", rdy_b, 0);
        chk("R1 irq after reset", irq, 0);
    endtask

    task automatic t_output();
        ctl(8'h83);                       // R2 enable-only word
        ctl(8'h45);                       // R2 ignored byte
        wr(8'hA5);
        chk("R3 rdy_a after load", rdy_a, 1);
        chk("R3 pin_oe output mode", pin_oe, 8'hFF);   // also R2: mode kept
        chk("R3 pin_out data", pin_out, 8'hA5);
        chk("R3 no early irq", irq, 0);
        stb_a_n = 1'b0; tick();
        chk("R4 rdy_a held during strobe", rdy_a, 1);
        stb_a_n = 1'b1; tick();
        chk("R4 rdy_a drops on strobe end", rdy_a, 0);
        chk("R4 irq on ack", irq, 1);
        tick();
        chk("R11 irq sticky", irq, 1);
        ack();
        chk("R11 irq cleared by ack", irq, 0);
    endtask

    task automatic t_input();
        ctl(8'h4F);
        chk("R5 rdy_a empty input", rdy_a, 1);
        chk("R5 pins released", pin_oe, 8'h00);
        pin_in = 8'h3C; stb_a_n = 1'b0; tick();
        pin_in = 8'h5A; tick();
        stb_a_n = 1'b1; pin_in = 8'h00; tick();
        chk("R5 rdy_a low when full", rdy_a, 0);
        chk("R5 irq on input", irq, 1);
        ack();
        pin_in = 8'hFF; stb_a_n = 1'b0; tick();
        stb_a_n = 1'b1; tick();
        chk("R6 no irq while full", irq, 0);
        chk("R6 data kept", cpu_dout, 8'h5A);
        rd_data = 1'b1; tick(); rd_data = 1'b0;
        chk("R6 rdy_a after read", rdy_a, 1);
    endtask

    task automatic t_bidir();
        pin_in = 8'h00;
        ctl(8'h8F);
        chk("R7 rdy_a idle bidir", rdy_a, 0);
        chk("R8 rdy_b empty bidir", rdy_b, 1);
        chk("R7 bus off idle", pin_oe, 8'h00);
        wr(8'h77);
        chk("R7 rdy_a pending", rdy_a, 1);
        chk("R7 bus off without strobe", pin_oe, 8'h00);
        stb_a_n = 1'b0; #1;
        chk("R7 bus on with strobe", pin_oe, 8'hFF);
        chk("R7 bus data", pin_out, 8'h77);
        tick();
        stb_a_n = 1'b1; #1;
        chk("R7 bus off after strobe", pin_oe, 8'h00);
        tick();
        chk("R7 rdy_a drops", rdy_a, 0);
        ack();
        pin_in = 8'h99; stb_b_n = 1'b0; tick();
        stb_b_n = 1'b1; tick();
        chk("R8 rdy_b full", rdy_b, 0);
        chk("R8 irq on b input", irq, 1);
        chk("R8 data in", cpu_dout, 8'h99);
        rd_data = 1'b1; tick(); rd_data = 1'b0;
        chk("R8 rdy_b after read", rdy_b, 1);
        ack();
        ctl(8'h0F);
        chk("R8 rdy_b outside bidir", rdy_b, 0);
    endtask

    task automatic t_control();
        pin_in = 8'h00;
        ctl(8'hA7);                      // enable, OR, high, no mask
        ctl(8'hCF);
        ctl(8'hF0);                      // R9 upper nibble inputs
        chk("R9 dir sets pin_oe", pin_oe, 8'h0F);
        wr(8'h05);
        chk("R9 rdy_a low", rdy_a, 0);
        chk("R9 pin_out", pin_out, 8'h05);
        pin_in = 8'hA0; #1;
        chk("R9 mixed read", cpu_dout, 8'hA5);
        tick();
        pin_in = 8'hF0; tick();
        chk("R10 empty watch no irq", irq, 0);
        stb_a_n = 1'b0; tick(); stb_a_n = 1'b1; tick();
        chk("R9 strobe ignored rdy", rdy_a, 0);
        chk("R9 strobe ignored irq", irq, 0);
        pin_in = 8'h00;
        ctl(8'hB7); ctl(8'h30);          // OR, high, watch bits 5:4
        tick();
        chk("R10 OR idle", irq, 0);
        pin_in = 8'h10; tick();
        chk("R10 OR match", irq, 1);
        ack();
        chk("R10 no repeat", irq, 0);
        pin_in = 8'h00;
        ctl(8'hF7); ctl(8'h30);          // AND, high
        pin_in = 8'h10; tick();
        chk("R10 AND partial", irq, 0);
        pin_in = 8'h30; tick();
        chk("R10 AND match", irq, 1);
        ack();
        pin_in = 8'h00;
        ctl(8'hB7); ctl(8'h01);          // watch an output bit only
        pin_in = 8'hFF; tick();
        chk("R10 output bit not watched", irq, 0);
    endtask

    task automatic t_irq_off();
        pin_in = 8'h00;
        ctl(8'h0F);
        ctl(8'h03);                      // R2 enable-only word, disable
        wr(8'h11);
        stb_a_n = 1'b0; tick(); stb_a_n = 1'b1; tick();
        chk("R11 handshake done", rdy_a, 0);
        chk("R11 no irq when disabled", irq, 0);
    endtask

    initial begin
        tick();
        t_reset();
        t_output();
        t_input();
        t_bidir();
        t_control();
        t_irq_off();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule